// File: doc/BRIEF.md
# Sequential Page Table Walker

The walker turns a virtual address into a page-granular page table entry by reading a tree of in-memory tables, one entry per level, through a simple memory port. A request carries the virtual address, a store flag and the physical base of the top table. The walker starts at the top level. At each step it forms the entry address, reads it and decides what to do next. Each entry is either a pointer to the next table, a leaf, or invalid. When it finds a leaf, it sets the referenced flag, and also the dirty flag on a store, and writes the entry back in place. A leaf found above the last level maps a large page. For such a leaf, the low virtual page number bits are ORed into the returned entry, so the caller always receives a 4 KiB mapping. A zero result means the walk failed.

The request side is a valid/ready handshake. `req_ready` is high only while the walker is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and a requester that sees `req_ready` low must hold its request. The result has no back-pressure: `done` is a single-cycle pulse, and `result` is valid during that pulse. The memory port has no stall. A read issued with `mem_req` high and `mem_we` low returns its data with `mem_rvalid` exactly one cycle later. A write with `mem_we` high takes effect at the clock edge.

Top module: `ptw_top`

## Requirements
- R1: An address whose bits 63 down to 38 are not all equal is rejected with no memory access: `done` pulses in the cycle right after acceptance, with `result` zero.
- R2: The walk uses three levels with 9-bit indices, taken in order from address bits [38:30], then [29:21], then [20:12]. Pages are 4 KiB and entries are 8 bytes.
- R3: The entry address is the current base plus the index times 8. If that address is at or beyond `MEM_SIZE`, no read is issued and the result is zero.
- R4: An entry with bit 0 (valid) clear ends the walk with result zero and no write-back.
- R5: A valid entry with bit 1 (table) set is a pointer, and the entry with its low 12 bits cleared becomes the next base. A pointer found at the last level gives result zero.
- R6: A valid entry with bit 1 clear is a leaf. It is written back to its own address with bit 2 (referenced) set, and with bit 3 (dirty) also set when the request is a store.
- R7: For a leaf at level 0 or 1, the virtual page number bits below that level (18 or 9 bits) are ORed into the result at bit 12 upward. The result also carries the referenced and dirty bits.
- R8: If the leaf's resulting page address (result with its low 12 bits cleared) is at or beyond `MEM_SIZE`, the result is zero, but the write-back still happens.
- R9: `req_ready` is high only in the idle state, and a request offered while busy has no effect. `done` lasts exactly one cycle, and no memory request is made while idle.
- R10: Counting edges after the accepting edge, `done` rises after 2i+1 edges for an out-of-range entry address at level i, after 2i+2 edges for an invalid entry or a pointer at the last level, and after 2i+3 edges for a leaf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle; request taken when both high |
| req_va | input | 64 | Virtual address to translate |
| req_store | input | 1 | Access is a store (sets dirty) |
| req_base | input | 64 | Physical base of the top-level table |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Page-granular entry, or zero on failure |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 64 | Byte address of the entry |
| mem_wdata | output | 64 | Entry written back |
| mem_rvalid | input | 1 | Read data valid, one cycle after a read |
| mem_rdata | input | 64 | Entry read from memory |

## Verification
The bench drives ordinary 4 KiB walks through all three levels, as loads and as stores, so that the referenced-only and referenced-plus-dirty write-backs are told apart. Large-page leaves at levels 0 and 1 test the width of the merged virtual page field. A negative sign-extended address is contrasted with a badly extended one, which must produce no memory traffic. Failures are placed at each point of the walk: a bad entry address at level 0 and at level 2, an invalid entry, a pointer at the last level, and an oversized leaf. Each must give zero after its own edge count, and only the oversized leaf may write memory. A request offered mid-walk shows that busy-time offers are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int BIT_V = 0;
  localparam int BIT_T = 1;
  localparam int BIT_R = 2;
  localparam int BIT_D = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_CHECK,
    S_WB,
    S_DONE
  } walk_state_t;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int XLEN = 64,
  parameter int LEVELS = 3,
  parameter int IDX_W = 9,
  parameter int PG_SHIFT = 12,
  parameter int PTE_BYTES = 8,
  parameter int LVL_W = 2,
  parameter logic [XLEN-1:0] MEM_SIZE = 64'h1000_0000
) (
  input  logic [XLEN-1:0]  va,
  input  logic [XLEN-1:0]  base,
  input  logic [LVL_W-1:0] level,
  output logic [XLEN-1:0]  pte_addr,
  output logic             in_range
);
  localparam int OFF_SHIFT = $clog2(PTE_BYTES);

  logic [IDX_W-1:0] idx_by_lvl [LEVELS];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_by_lvl[g] = va[PG_SHIFT + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int l = 0; l < LEVELS; l++)
      if (level == LVL_W'(l)) idx = idx_by_lvl[l];
  end

  assign pte_addr = base + (XLEN'(idx) << OFF_SHIFT);
  assign in_range = pte_addr < MEM_SIZE;
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf #(
  parameter int XLEN = 64,
  parameter int LEVELS = 3,
  parameter int IDX_W = 9,
  parameter int PG_SHIFT = 12,
  parameter int LVL_W = 2,
  parameter logic [XLEN-1:0] MEM_SIZE = 64'h1000_0000
) (
  input  logic [XLEN-1:0]  pte,
  input  logic [XLEN-1:0]  va,
  input  logic             store,
  input  logic [LVL_W-1:0] level,
  output logic [XLEN-1:0]  wb_pte,
  output logic [XLEN-1:0]  leaf_pte,
  output logic             in_range
);
  import ptw_pkg::*;

  logic [XLEN-1:0] lo_mask [LEVELS];
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] vpn;
  logic [XLEN-1:0] page;

  for (genvar g = 0; g < LEVELS; g++) begin : g_mask
    assign lo_mask[g] = (XLEN'(1) << ((LEVELS-1-g)*IDX_W)) - XLEN'(1);
  end

  always_comb begin
    mask = '0;
    for (int l = 0; l < LEVELS; l++)
      if (level == LVL_W'(l)) mask = lo_mask[l];
  end

  assign wb_pte   = pte | (XLEN'(1) << BIT_R) | (store ? (XLEN'(1) << BIT_D) : '0);
  assign vpn      = va >> PG_SHIFT;
  assign leaf_pte = wb_pte | ((vpn & mask) << PG_SHIFT);
  assign page     = leaf_pte & ~((XLEN'(1) << PG_SHIFT) - XLEN'(1));
  assign in_range = page < MEM_SIZE;
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
  parameter int XLEN = 64,
  parameter int LEVELS = 3,
  parameter int IDX_W = 9,
  parameter int PG_SHIFT = 12,
  parameter int PTE_BYTES = 8,
  parameter logic [XLEN-1:0] MEM_SIZE = 64'h1000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] req_va,
  input  logic            req_store,
  input  logic [XLEN-1:0] req_base,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata
);
  import ptw_pkg::*;

  localparam int VA_BITS = PG_SHIFT + LEVELS*IDX_W;
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);
  localparam int UP_W = XLEN - VA_BITS + 1;

  walk_state_t     state;
  logic [XLEN-1:0] va_q, base_q, addr_q, wb_q, result_q;
  logic            store_q;
  logic [LVL_W-1:0] level_q;

  logic [XLEN-1:0] pte_addr, wb_pte, leaf_pte;
  logic            addr_ok, leaf_ok, va_ok;
  logic [UP_W-1:0] va_upper;

  assign va_upper = req_va[XLEN-1:VA_BITS-1];
  assign va_ok    = (&va_upper) | ~(|va_upper);

  ptw_index #(
    .XLEN(XLEN), .LEVELS(LEVELS), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT),
    .PTE_BYTES(PTE_BYTES), .LVL_W(LVL_W), .MEM_SIZE(MEM_SIZE)
  ) u_index (
    .va(va_q), .base(base_q), .level(level_q),
    .pte_addr(pte_addr), .in_range(addr_ok)
  );

  ptw_leaf #(
    .XLEN(XLEN), .LEVELS(LEVELS), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT),
    .LVL_W(LVL_W), .MEM_SIZE(MEM_SIZE)
  ) u_leaf (
    .pte(mem_rdata), .va(va_q), .store(store_q), .level(level_q),
    .wb_pte(wb_pte), .leaf_pte(leaf_pte), .in_range(leaf_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      va_q     <= '0;
      base_q   <= '0;
      addr_q   <= '0;
      wb_q     <= '0;
      result_q <= '0;
      store_q  <= 1'b0;
      level_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q     <= req_va;
          store_q  <= req_store;
          base_q   <= req_base;
          level_q  <= '0;
          result_q <= '0;
          state    <= va_ok ? S_READ : S_DONE;
        end
        S_READ: begin
          addr_q <= pte_addr;
          state  <= addr_ok ? S_CHECK : S_DONE;
        end
        S_CHECK: if (mem_rvalid) begin
          if (!mem_rdata[BIT_V]) begin
            state <= S_DONE;
          end else if (mem_rdata[BIT_T]) begin
            base_q <= {mem_rdata[XLEN-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
            if (level_q == LAST_LVL) begin
              state <= S_DONE;
            end else begin
              level_q <= level_q + 1'b1;
              state   <= S_READ;
            end
          end else begin
            wb_q     <= wb_pte;
            result_q <= leaf_ok ? leaf_pte : '0;
            state    <= S_WB;
          end
        end
        S_WB:    state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign result    = result_q;
  assign mem_req   = ((state == S_READ) && addr_ok) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_addr  = (state == S_WB) ? addr_q : pte_addr;
  assign mem_wdata = wb_q;

  // R1
  sign_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !va_ok) |=> (done && result == '0));

  // R3
  read_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr < MEM_SIZE));

  // R6
  wb_referenced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[BIT_R] && !mem_wdata[BIT_T]));

  // R6
  wb_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_rvalid));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  // R5
  leaf_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != '0) |-> (result[BIT_V] && !result[BIT_T]));
endmodule

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
module tb_ptw_top;
  localparam logic [63:0] MEMSZ = 64'h40_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        req_store = 1'b0;
  logic [63:0] req_base = '0;
  logic        done;
  logic [63:0] result;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  ptw_top #(.MEM_SIZE(MEMSZ)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_store(req_store), .req_base(req_base),
    .done(done), .result(result), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [63:0] mem [logic [63:0]];
  int          wr_cnt = 0;
  logic [63:0] last_wa = '0, last_wd = '0;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // memory: one-cycle read latency, writes at the edge
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
        last_wa = mem_addr;
        last_wd = mem_wdata;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(mem_addr);
      end
    end
  end

  // behavioural reference of one walk
  task automatic ref_walk(input logic [63:0] va, input bit st, input logic [63:0] base,
                          output logic [63:0] res, output int k, output bit wb,
                          output logic [63:0] wa, output logic [63:0] wd);
    logic [63:0] b, a, p, m;
    logic [25:0] top;
    res = 0; wb = 0; wa = 0; wd = 0; k = 6;
    top = va[63:38];
    if (!(top == '0 || top == '1)) begin k = 0; return; end  // R1
    b = base;
    for (int i = 0; i < 3; i++) begin
      int sh;
      sh = (2 - i) * 9;
      a = b + (((va >> (12 + sh)) & 64'h1FF) * 8);          // R2
      if (a >= MEMSZ) begin k = 2*i + 1; return; end        // R3
      p = rd(a);
      if (!p[0]) begin k = 2*i + 2; return; end             // R4
      if (p[1]) begin b = (p >> 12) << 12; continue; end    // R5
      wb = 1; wa = a;
      wd = p | 64'h4 | (st ? 64'h8 : 64'h0);                // R6
      m  = wd | (((va >> 12) & ((64'd1 << sh) - 1)) << 12); // R7
      res = (((m >> 12) << 12) >= MEMSZ) ? 64'h0 : m;       // R8
      k = 2*i + 3;
      return;
    end
  endtask

  bit          run_on = 1'b0;
  bit          busy = 1'b0;
  int          left = 0;
  logic [63:0] e_res, e_wa, e_wd;
  bit          e_wb;
  int          wr0 = 0;

  always @(negedge clk) begin
    if (run_on) begin
      chk(req_ready == !busy, "R9 ready", 64'(req_ready), 64'(!busy));
      chk(done == (busy && left == 0), "R10 done timing", 64'(done), 64'(busy && left == 0));
      if (!busy) chk(!mem_req, "R9 idle quiet", 64'(mem_req), 64'h0);
      if (busy && left == 0) begin
        chk(result == e_res, "R6/R7/R8 result", result, e_res);
        chk(wr_cnt == wr0 + (e_wb ? 1 : 0), "R4/R6 write count", 64'(wr_cnt), 64'(wr0 + (e_wb ? 1 : 0)));
        if (e_wb) begin
          chk(last_wa == e_wa, "R6 wb addr", last_wa, e_wa);
          chk(last_wd == e_wd, "R6 wb data", last_wd, e_wd);
        end
      end
      if (busy) begin
        if (left == 0) busy = 1'b0;
        else left--;
      end else if (req_valid) begin
        ref_walk(req_va, req_store, req_base, e_res, left, e_wb, e_wa, e_wd);
        wr0  = wr_cnt;
        busy = 1'b1;
      end
    end
  end

  task automatic run(input logic [63:0] va, input bit st, input logic [63:0] base, input int junk_at);
    @(posedge clk); #1;
    req_va = va; req_store = st; req_base = base; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int c = 0; busy; c++) begin
      if (c == junk_at) begin
        req_va = 64'h0000_0000_4060_5000; req_store = 1'b1; req_valid = 1'b1;  // R9 offer while busy
      end else begin
        req_valid = 1'b0;
      end
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  localparam logic [63:0] ROOT = 64'h1000;

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
  end

  initial begin
    mem[ROOT + 1*8]      = 64'h2003;        // level0 idx1 -> table 0x2000
    mem[ROOT + 9'h100*8] = 64'h2003;        // negative half -> same table
    mem[ROOT]            = 64'h0000_00F1;   // level0 idx0 leaf, 1 GiB page at 0
    mem[64'h2000 + 3*8]  = 64'h3003;        // level1 idx3 -> table 0x3000
    mem[64'h2000 + 4*8]  = 64'h20_00F1;     // level1 idx4 leaf, 2 MiB page
    mem[64'h2000 + 5*8]  = 64'h50_0003;     // pointer beyond memory
    mem[64'h2000 + 8*8]  = 64'h50_0001;     // leaf beyond memory
    mem[64'h3000 + 5*8]  = 64'h8_00F1;      // level2 leaf
    mem[64'h3000 + 9*8]  = 64'h4003;        // pointer at last level
    for (int i = 10; i < 18; i++) mem[64'h3000 + 64'(i)*8] = (64'(i + 64'h100) << 12) | 64'h1;

    repeat (3) @(posedge clk);
    #4;
    chk(req_ready == 1'b1, "R9 reset ready", 64'(req_ready), 64'h1);
    chk(done == 1'b0, "R9 reset done", 64'(done), 64'h0);
    chk(mem_req == 1'b0, "R9 reset mem_req", 64'(mem_req), 64'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_on = 1'b1;

    run(64'h0000_0000_4060_5123, 1'b0, ROOT, -1);   // R2 R6 three-level load
    run(64'h0000_0000_4060_5123, 1'b1, ROOT, -1);   // R6 store sets dirty
    run(64'h0000_0000_4080_7ABC, 1'b0, ROOT, -1);   // R7 2 MiB leaf
    run(64'h0000_0000_0012_3456, 1'b1, ROOT, -1);   // R7 1 GiB leaf
    run(64'h0000_0000_40C0_0000, 1'b0, ROOT, -1);   // R4 invalid at level 1
    run(64'h0000_0080_0000_0000, 1'b0, ROOT, -1);   // R1 bad sign extension
    run(64'hFFFF_FFC0_0060_5010, 1'b0, ROOT, -1);   // R1 good negative address
    run(64'h0000_0000_4060_5000, 1'b0, MEMSZ, -1);  // R3 entry address beyond memory
    run(64'h0000_0000_40A0_0000, 1'b0, ROOT, -1);   // R3 beyond memory at level 2
    run(64'h0000_0000_4100_0000, 1'b1, ROOT, -1);   // R8 leaf beyond memory
    run(64'h0000_0000_4060_9000, 1'b0, ROOT, -1);   // R5 pointer at last level
    run(64'h0000_0000_4060_C000, 1'b0, ROOT, 1);    // R9 offer while busy ignored
    for (int i = 10; i < 18; i++)
      run(64'h0000_0000_4060_0000 | (64'(i) << 12) | 64'(i*8), i[0], ROOT, -1);  // R2 R10 sweep
    repeat (3) @(posedge clk);
    summary();
  end
endmodule